// File: doc/BRIEF.md
# Word-Wide CRC-32 Accumulator

This unit keeps a running CRC-32 over a stream of 32-bit words written to it through a two-register map. Software or a sequencer reloads the checksum through the control register. It then writes each word of a memory image to the data register and reads the data register back to get the current checksum. The generator is 0x04C11DB7 in normal form. Each word enters most-significant byte first with no bit reflection and no output inversion. An image with its own checksum appended as a final word therefore leaves a residue of zero.

The parameter `STEP_BITS` sets how many bits are folded per clock. With 32, a word is absorbed on the clock edge that accepts it. With a smaller divisor of 32, the first slice is folded on the accepting edge and the rest over `32/STEP_BITS - 1` further cycles, while a busy flag stays high.

Top module: `crcw_unit`

## Requirements
- R1: A word written to the data register (word index 0) is folded into the checksum with polynomial 0x04C11DB7. Bits enter from bit 31 down to bit 0: shift left, and XOR in the polynomial when the data bit XOR the outgoing checksum bit is 1. The data register reads back the raw checksum, with no reflection and no final XOR.
- R2: After the synchronous reset the checksum reads 0xFFFFFFFF and busy is 0.
- R3: Writing 1 to bit 0 of the control register (word index 1) reloads the checksum to 0xFFFFFFFF. Writing 0 there changes nothing.
- R4: A reload written while a word is still being folded abandons that word. The checksum is 0xFFFFFFFF and busy is 0 on the next cycle.
- R5: From 0xFFFFFFFF, the word 0xFFFFFFFF gives 0. From 0, the word 0 gives 0. From 0xFFFFFFFF, the word 0x00000000 gives 0xC704DD7B.
- R6: Successive words chain, and appending the checksum of a word sequence as one more word leaves 0.
- R7: After an accepted data write, busy is 1 for exactly 32/STEP_BITS - 1 cycles. The checksum is final once busy is 0.
- R8: A data-register write while busy is 1 is dropped and does not alter the result.
- R9: Writes to word indices other than 0 and 1 have no effect, and reads of them return 0.
- R10: The control register reads back with bit 1 equal to busy and every other bit 0, including the self-clearing reload bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word index of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| busy | output | 1 | A word is still being folded |

## Verification
A data write is sampled on one rising edge. Busy is high from just after that edge for `32/STEP_BITS - 1` cycles, and the checksum is final on the following falling edge. With `STEP_BITS = 8` the bench writes at a falling edge and checks busy at the next falling edge. It then waits exactly three more falling edges before it compares the checksum. A reload is visible one falling edge after the write. Reads are combinational, so each is sampled a short delay after the address changes, away from any rising edge.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    // register word indices
    localparam int unsigned REG_DATA = 0;
    localparam int unsigned REG_CTRL = 1;

    // control register bit positions
    localparam int unsigned CTRL_RELOAD_BIT = 0;
    localparam int unsigned CTRL_BUSY_BIT   = 1;

    typedef logic [WORD_W-1:0] crc_word_t;

    // decoded bus command
    typedef struct packed {
        logic reload;
        logic feed;
    } crcw_cmd_t;

    typedef enum logic [1:0] {
        SEL_DATA,
        SEL_CTRL,
        SEL_NONE
    } crcw_sel_e;

    // one serial step of the normal-form CRC register
    function automatic crc_word_t crc_bit_step(input crc_word_t cur, input logic din);
        logic fb;
        fb = cur[WORD_W-1] ^ din;
        return {cur[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/crcw_fold.sv
module crcw_fold
    import crcw_pkg::*;
#(
    parameter int unsigned CHUNK = 8
) (
    input  crc_word_t        crc_in,
    input  logic [CHUNK-1:0] chunk,
    output crc_word_t        crc_out
);

    crc_word_t stage [0:CHUNK];

    assign stage[0] = crc_in;

    generate
        for (genvar i = 0; i < CHUNK; i++) begin : g_bit
            assign stage[i+1] = crc_bit_step(stage[i], chunk[CHUNK-1-i]);
        end
    endgenerate

    assign crc_out = stage[CHUNK];

endmodule

// File: rtl/crcw_regs.sv
module crcw_regs
    import crcw_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ctrl_reload,
    input  logic              busy,
    input  crc_word_t         crc_value,
    output crcw_cmd_t         cmd,
    output crc_word_t         bus_rdata
);

    crcw_sel_e sel;

    always_comb begin
        if (bus_addr == ADDR_W'(REG_DATA))      sel = SEL_DATA;
        else if (bus_addr == ADDR_W'(REG_CTRL)) sel = SEL_CTRL;
        else                                    sel = SEL_NONE;
    end

    always_comb begin
        cmd.feed   = bus_wr && (sel == SEL_DATA) && !busy;
        cmd.reload = bus_wr && (sel == SEL_CTRL) && ctrl_reload;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA: bus_rdata = crc_value;
            SEL_CTRL: bus_rdata[CTRL_BUSY_BIT] = busy;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crcw_engine.sv
module crcw_engine
    import crcw_pkg::*;
#(
    parameter int unsigned STEP_BITS = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  crcw_cmd_t cmd,
    input  crc_word_t word_in,
    output crc_word_t crc_value,
    output logic      busy
);

    localparam int unsigned STEPS = WORD_W / STEP_BITS;
    localparam int unsigned CNT_W = $clog2(STEPS) + 1;

    crc_word_t          crc_q;
    crc_word_t          pend_q;
    logic [CNT_W-1:0]   left_q;
    logic [STEP_BITS-1:0] slice;
    crc_word_t          fold_out;
    crc_word_t          pend_next;

    assign slice = cmd.feed ? word_in[WORD_W-1 -: STEP_BITS]
                            : pend_q[WORD_W-1 -: STEP_BITS];

    crcw_fold #(.CHUNK(STEP_BITS)) u_fold (
        .crc_in (crc_q),
        .chunk  (slice),
        .crc_out(fold_out)
    );

    generate
        if (STEPS == 1) begin : g_single
            assign pend_next = '0;
        end else begin : g_multi
            assign pend_next = cmd.feed ? {word_in[WORD_W-STEP_BITS-1:0], {STEP_BITS{1'b0}}}
                                        : {pend_q[WORD_W-STEP_BITS-1:0], {STEP_BITS{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= CRC_SEED;
            pend_q <= '0;
            left_q <= '0;
        end else if (cmd.reload) begin
            crc_q  <= CRC_SEED;
            pend_q <= '0;
            left_q <= '0;
        end else if (cmd.feed) begin
            crc_q  <= fold_out;
            pend_q <= pend_next;
            left_q <= CNT_W'(STEPS - 1);
        end else if (left_q != '0) begin
            crc_q  <= fold_out;
            pend_q <= pend_next;
            left_q <= left_q - 1'b1;
        end
    end

    assign crc_value = crc_q;
    assign busy      = (left_q != '0);

endmodule

// File: rtl/crcw_unit.sv
module crcw_unit
    import crcw_pkg::*;
#(
    parameter int unsigned STEP_BITS = 8,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              busy
);

    crcw_cmd_t cmd;
    crc_word_t crc_value;
    logic      busy_int;

    crcw_regs #(.ADDR_W(ADDR_W)) u_regs (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .ctrl_reload(bus_wdata[CTRL_RELOAD_BIT]),
        .busy       (busy_int),
        .crc_value  (crc_value),
        .cmd        (cmd),
        .bus_rdata  (bus_rdata)
    );

    crcw_engine #(.STEP_BITS(STEP_BITS)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .word_in  (bus_wdata),
        .crc_value(crc_value),
        .busy     (busy_int)
    );

    assign busy = busy_int;

endmodule

// File: rtl/crcw_chk.sv
module crcw_chk
    import crcw_pkg::*;
#(
    parameter int unsigned STEP_BITS = 8,
    parameter int unsigned ADDR_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              reload_bit,
    input logic              busy,
    input crc_word_t         crc_value
);

    localparam int unsigned STEPS = WORD_W / STEP_BITS;

    logic       wr_data, wr_ctrl, wr_other;
    logic [7:0] busy_run;

    assign wr_data  = bus_wr && bus_addr == ADDR_W'(REG_DATA);
    assign wr_ctrl  = bus_wr && bus_addr == ADDR_W'(REG_CTRL);
    assign wr_other = bus_wr && !wr_data && !wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= '0;
        else              busy_run <= busy_run + 1'b1;
    end

    a_r2_reset_seed: assert property (@(posedge clk)
        $past(rst) |-> (crc_value == CRC_SEED && !busy));

    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && reload_bit) |=> (crc_value == CRC_SEED && !busy));

    a_r7_busy_after_feed: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !busy) |=> (busy == (STEPS > 1)));

    a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < 8'(STEPS - 1)));

    a_r9_other_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_other && !busy) |=> $stable(crc_value));

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_data && !(wr_ctrl && reload_bit)) |=> $stable(crc_value));

endmodule

bind crcw_unit crcw_chk #(.STEP_BITS(STEP_BITS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .reload_bit(bus_wdata[crcw_pkg::CTRL_RELOAD_BIT]),
    .busy      (busy),
    .crc_value (u_engine.crc_value)
);

// File: tb/sim_crcw_unit.sv
`timescale 1ns/1ps
module sim_crcw_unit;

    localparam int STEP_BITS = 8;
    localparam int ADDR_W    = 2;
    localparam int STEPS     = 32 / STEP_BITS;
    localparam logic [31:0] POLY = 32'h04C11DB7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    crcw_unit #(.STEP_BITS(STEP_BITS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c ^ w;
        for (int k = 0; k < 32; k++)
            r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = ADDR_W'(a);
        #1 v = bus_rdata;
    endtask

    // write, returning at the falling edge after the capturing rising edge
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic feed(input logic [31:0] d);
        wr(0, d);
        repeat (STEPS - 1) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v);
        check("R2 seed", v, 32'hFFFFFFFF);
        check("R2 busy", {31'b0, busy}, 32'd0);
    endtask

    task automatic t_vectors();
        logic [31:0] v;
        wr(1, 32'h1);
        feed(32'hFFFFFFFF);
        rd(0, v);
        check("R5 ones", v, 32'h0);
        feed(32'h0);
        rd(0, v);
        check("R5 zero on zero", v, 32'h0);
        wr(1, 32'h1);
        feed(32'h0);
        rd(0, v);
        check("R5 seed with zero", v, 32'hC704DD7B);
        check("R1 model agrees", v, ref_crc(32'hFFFFFFFF, 32'h0));
    endtask

    task automatic t_chain();
        logic [31:0] v, e;
        logic [31:0] words [4] = '{32'h12345678, 32'hDEADBEEF, 32'h00000001, 32'h80000000};
        wr(1, 32'h1);
        e = 32'hFFFFFFFF;
        foreach (words[i]) begin
            feed(words[i]);
            e = ref_crc(e, words[i]);
            rd(0, v);
            check("R1 R6 chain", v, e);
        end
        feed(e);
        rd(0, v);
        check("R6 residue", v, 32'h0);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(1, 32'h1);
        wr(0, 32'hA5A5A5A5);
        check("R7 busy rises", {31'b0, busy}, 32'd1);
        bus_addr = ADDR_W'(1);
        #1 check("R10 ctrl busy", bus_rdata, 32'h2);
        repeat (STEPS - 2) @(negedge clk);
        check("R7 busy held", {31'b0, busy}, 32'd1);
        @(negedge clk);
        check("R7 busy falls", {31'b0, busy}, 32'd0);
        rd(0, v);
        check("R7 final", v, ref_crc(32'hFFFFFFFF, 32'hA5A5A5A5));
        rd(1, v);
        check("R10 ctrl idle", v, 32'h0);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        wr(1, 32'h1);
        wr(0, 32'h0F0F0F0F);
        wr(0, 32'h55555555);
        repeat (STEPS) @(negedge clk);
        rd(0, v);
        check("R8 dropped", v, ref_crc(32'hFFFFFFFF, 32'h0F0F0F0F));
    endtask

    task automatic t_reload();
        logic [31:0] v;
        feed(32'h11223344);
        wr(1, 32'h0);
        rd(0, v);
        check("R3 zero write", v, ref_crc(ref_crc(32'hFFFFFFFF, 32'h0F0F0F0F), 32'h11223344));
        wr(1, 32'h1);
        rd(0, v);
        check("R3 reload", v, 32'hFFFFFFFF);
        wr(0, 32'hCAFEF00D);
        wr(1, 32'h1);
        check("R4 busy cleared", {31'b0, busy}, 32'd0);
        rd(0, v);
        check("R4 abandoned", v, 32'hFFFFFFFF);
        rd(1, v);
        check("R10 self clear", v, 32'h0);
    endtask

    task automatic t_other();
        logic [31:0] v;
        feed(32'h01020304);
        wr(2, 32'hFFFFFFFF);
        wr(3, 32'h1);
        rd(0, v);
        check("R9 write ignored", v, ref_crc(32'hFFFFFFFF, 32'h01020304));
        rd(2, v);
        check("R9 read zero", v, 32'h0);
        rd(3, v);
        check("R9 read zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_vectors();
        t_chain();
        t_busy();
        t_drop();
        t_reload();
        t_other();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule